// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block turns the two sampled wires of a low-speed USB link into packet bytes. It runs on a local clock that is `OSR` times the nominal 1.5 Mbit/s bit rate. While idle it waits for the line to go from the idle level to the opposite level. It then follows the alternating sync field and locks on when it sees the doubled level that ends the sync. From there it decodes NRZI, drops stuffed bits and packs each group of eight data bits into a byte, least significant bit first.

Each finished byte leaves on a single-cycle write strobe with its buffer index, and the indices count up from zero. A single-ended-zero state ends the packet. The block then pulses a done flag together with the number of bytes it stored and a flag that tells the consumer to discard the packet, either because the packet was longer than the buffer or because an illegal line state appeared. A sync field that breaks off early raises its own pulse, and the block goes back to waiting. The inputs must already be synchronised to `clk`.

Top module: `usbls_rx`

## Requirements
- R1: While and right after `rst` is high, `wr_en`, `pkt_done` and `sync_abort` are low, and an idle line (J: `dp`=0, `dm`=1) produces none of them.
- R2: A packet starts on a J-to-K edge (K: `dp`=1, `dm`=0). Line levels that alternate from bit to bit are sync. Two consecutive K samples end the sync, and the bits after them are data.
- R3: During sync, two consecutive J samples, an SE0 sample (both low) or a both-high sample give a one-cycle `sync_abort`. No bytes or `pkt_done` follow, and the next J-to-K edge starts a fresh hunt.
- R4: A data bit is 1 when its level equals the previous bit's level and 0 when it differs. Bits fill bytes LSB first. Each completed byte gives one `wr_en` cycle carrying `wr_data`, with `wr_idx` counting 0, 1, 2, ... within the packet.
- R5: After six consecutive decoded 1s, the next bit period is a stuffed bit. It only updates the reference level and adds nothing to the data. The final K of the sync counts as the first of those ones.
- R6: A decoded 0 clears the run of ones, so runs of five ones separated by zeros decode with no bit removed.
- R7: An SE0 sample during data ends the packet. `pkt_done` pulses for one cycle, and `pkt_len` holds the number of complete bytes. Trailing bits that do not fill a byte are dropped. An empty packet reports 0.
- R8: Bytes beyond `DEPTH` are not written. The packet then ends with `pkt_len` = `DEPTH` and `pkt_ignored` = 1. A packet of exactly `DEPTH` bytes has `pkt_ignored` = 0.
- R9: A both-high sample during data ends the packet with `pkt_done` and `pkt_ignored` = 1. `pkt_len` keeps the count of bytes stored so far.
- R10: Each line transition re-times sampling to `OSR/2` cycles after the transition, repeating every `OSR` cycles. Packets in which every fourth bit is one clock longer or one clock shorter than `OSR` decode correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, `OSR` cycles per bit |
| rst | input | 1 | Synchronous reset, active high |
| dp | input | 1 | Synchronised D+ sample |
| dm | input | 1 | Synchronised D- sample |
| wr_en | output | 1 | One-cycle byte write strobe |
| wr_idx | output | $clog2(DEPTH) | Buffer index of the byte |
| wr_data | output | 8 | Received byte |
| pkt_done | output | 1 | One-cycle end-of-packet pulse |
| pkt_len | output | $clog2(DEPTH+1) | Bytes stored in the packet |
| pkt_ignored | output | 1 | Packet must be discarded (overflow or illegal state) |
| sync_abort | output | 1 | One-cycle pulse for a broken sync field |

## Verification
The bench builds the block with `OSR` = 6 and `DEPTH` = 4. A buffer of four bytes lets short packets reach the overflow boundary and the exactly-full case. With six clocks per bit the sample point sits three clocks into each bit, so stretching or shrinking a bit by a single clock is a real timing offset that the resynchronisation has to absorb. The bench's own NRZI encoder inserts stuffed bits over the whole stream, sync included. This makes the stuffing position right after the sync, and the effect of zeros that break up runs, visible in the decoded bytes.

// File: rtl/usbls_rx_pkg.sv
package usbls_rx_pkg;

    // {dp, dm} levels on the wire
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_BAD = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_SYNC,
        ST_DATA
    } rx_state_e;

    typedef struct packed {
        logic vld;
        logic val;
    } bit_t;

    localparam int STUFF_RUN = 6;

    function automatic line_e classify(input logic dp, input logic dm);
        return line_e'({dp, dm});
    endfunction

    function automatic logic is_level(input line_e l);
        return (l == LN_J) || (l == LN_K);
    endfunction

endpackage

// File: rtl/usbls_rx_phase.sv
module usbls_rx_phase
    import usbls_rx_pkg::*;
#(
    parameter int OSR = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  line_e line,
    output logic  strobe,
    output logic  jk_edge
);
    localparam int PW   = $clog2(OSR);
    localparam int HALF = OSR / 2;

    line_e         prev_q;
    logic [PW-1:0] ph_q;
    logic          chg;

    assign chg     = (line != prev_q);
    assign strobe  = (ph_q == PW'(HALF)) && !chg;
    assign jk_edge = chg && (line == LN_K) && (prev_q == LN_J);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= LN_J;
            ph_q   <= '0;
        end else begin
            prev_q <= line;
            if (chg)
                ph_q <= PW'(1);
            else if (ph_q == PW'(OSR - 1))
                ph_q <= '0;
            else
                ph_q <= ph_q + PW'(1);
        end
    end

    // R10: sample points are at least a bit apart
    assert_strobe_spacing_R10: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

endmodule

// File: rtl/usbls_rx_nrzi.sv
module usbls_rx_nrzi
    import usbls_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  strobe,
    input  line_e line,
    input  logic  load,
    input  logic  active,
    output bit_t  bit_o
);
    line_e      ref_q;
    logic [2:0] ones_q;
    logic       stuff;
    logic       take;

    assign stuff     = (ones_q == 3'(STUFF_RUN));
    assign take      = active && strobe && is_level(line);
    assign bit_o.vld = take && !stuff;
    assign bit_o.val = (line == ref_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= LN_J;
            ones_q <= '0;
        end else if (load) begin
            ref_q  <= LN_K;
            ones_q <= 3'd1;        // closing K of sync is a one
        end else if (take) begin
            ref_q <= line;
            if (stuff || line != ref_q)
                ones_q <= '0;
            else
                ones_q <= ones_q + 3'd1;
        end
    end

    // R5: run of ones never passes the stuffing limit
    assert_stuff_run_R5: assert property (@(posedge clk) disable iff (rst)
        ones_q <= 3'(STUFF_RUN));

    // R5: the period after six ones yields no data bit
    assert_stuff_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (stuff && active && strobe) |-> !bit_o.vld);

endmodule

// File: rtl/usbls_rx_bytes.sv
module usbls_rx_bytes
    import usbls_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  bit_t                       bit_i,
    output logic                       wr_en,
    output logic [$clog2(DEPTH)-1:0]   wr_idx,
    output logic [7:0]                 wr_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovf
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [6:0]    sh_q;
    logic [2:0]    bc_q;
    logic [CW-1:0] cnt_q;
    logic          ovf_q;

    assign count = cnt_q;
    assign ovf   = ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            bc_q    <= '0;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (clear) begin
                bc_q  <= '0;
                cnt_q <= '0;
                ovf_q <= 1'b0;
            end else if (bit_i.vld) begin
                sh_q <= {bit_i.val, sh_q[6:1]};
                bc_q <= bc_q + 3'd1;
                if (bc_q == 3'd7) begin
                    if (cnt_q < CW'(DEPTH)) begin
                        wr_en   <= 1'b1;
                        wr_data <= {bit_i.val, sh_q};
                        wr_idx  <= cnt_q[IW-1:0];
                        cnt_q   <= cnt_q + CW'(1);
                    end else begin
                        ovf_q <= 1'b1;
                    end
                end
            end
        end
    end

    // R8: overflow is only declared once the buffer is full
    assert_ovf_full_R8: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> (cnt_q == CW'(DEPTH)));

    // R4: byte strobes are single cycles
    assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

endmodule

// File: rtl/usbls_rx.sv
module usbls_rx
    import usbls_rx_pkg::*;
#(
    parameter int OSR   = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       dp,
    input  logic                       dm,
    output logic                       wr_en,
    output logic [$clog2(DEPTH)-1:0]   wr_idx,
    output logic [7:0]                 wr_data,
    output logic                       pkt_done,
    output logic [$clog2(DEPTH+1)-1:0] pkt_len,
    output logic                       pkt_ignored,
    output logic                       sync_abort
);
    localparam int CW = $clog2(DEPTH + 1);

    line_e         line;
    logic          strobe;
    logic          jk_edge;
    rx_state_e     st_q;
    line_e         sref_q;
    logic          load;
    logic          active;
    bit_t          bit_w;
    logic [CW-1:0] cnt_w;
    logic          ovf_w;

    assign line   = classify(dp, dm);
    assign active = (st_q == ST_DATA);
    assign load   = (st_q == ST_SYNC) && strobe && (line == LN_K) && (sref_q == LN_K);

    usbls_rx_phase #(.OSR(OSR)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .line    (line),
        .strobe  (strobe),
        .jk_edge (jk_edge)
    );

    usbls_rx_nrzi u_nrzi (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .line   (line),
        .load   (load),
        .active (active),
        .bit_o  (bit_w)
    );

    usbls_rx_bytes #(.DEPTH(DEPTH)) u_bytes (
        .clk     (clk),
        .rst     (rst),
        .clear   (load),
        .bit_i   (bit_w),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .count   (cnt_w),
        .ovf     (ovf_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_HUNT;
            sref_q      <= LN_J;
            pkt_done    <= 1'b0;
            pkt_len     <= '0;
            pkt_ignored <= 1'b0;
            sync_abort  <= 1'b0;
        end else begin
            pkt_done   <= 1'b0;
            sync_abort <= 1'b0;
            case (st_q)
                ST_HUNT: begin
                    if (jk_edge) begin
                        st_q   <= ST_SYNC;
                        sref_q <= LN_J;
                    end
                end
                ST_SYNC: begin
                    if (strobe) begin
                        if (line == LN_K && sref_q == LN_K)
                            st_q <= ST_DATA;
                        else if (is_level(line) && line != sref_q)
                            sref_q <= line;
                        else begin
                            st_q       <= ST_HUNT;
                            sync_abort <= 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (strobe && !is_level(line)) begin
                        st_q        <= ST_HUNT;
                        pkt_done    <= 1'b1;
                        pkt_len     <= cnt_w;
                        pkt_ignored <= ovf_w || (line == LN_BAD);
                    end
                end
                default: st_q <= ST_HUNT;
            endcase
        end
    end

    // R7: end of packet is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        pkt_done |=> !pkt_done);

    // R7: a byte write and the end of packet never coincide
    assert_done_wr_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(pkt_done && wr_en));

    // R3: a broken sync never reports a packet
    assert_abort_no_done_R3: assert property (@(posedge clk) disable iff (rst)
        sync_abort |-> !pkt_done);

    // R8: reported length stays within the buffer
    assert_len_bound_R8: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> (pkt_len <= CW'(DEPTH)));

endmodule

// File: tb/usbls_rx_bench.sv
module usbls_rx_bench;
    localparam int OSR   = 6;
    localparam int DEPTH = 4;
    localparam int IW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dp  = 1'b0;
    logic          dm  = 1'b1;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [7:0]    wr_data;
    logic          pkt_done;
    logic [CW-1:0] pkt_len;
    logic          pkt_ignored;
    logic          sync_abort;

    always #2 clk = ~clk;

    usbls_rx #(.OSR(OSR), .DEPTH(DEPTH)) u_usbls_rx (
        .clk         (clk),
        .rst         (rst),
        .dp          (dp),
        .dm          (dm),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .pkt_done    (pkt_done),
        .pkt_len     (pkt_len),
        .pkt_ignored (pkt_ignored),
        .sync_abort  (sync_abort)
    );

    int nchk = 0;
    int nerr = 0;

    // monitor of output events
    int       nwr = 0;
    int       ndone = 0;
    int       nabort = 0;
    int       last_len = 0;
    int       last_ign = 0;
    logic [7:0] got_data [0:31];
    int         got_idx  [0:31];

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en && nwr < 32) begin
                got_data[nwr] = wr_data;
                got_idx[nwr]  = int'(wr_idx);
                nwr++;
            end
            if (pkt_done) begin
                ndone++;
                last_len = int'(pkt_len);
                last_ign = int'(pkt_ignored);
            end
            if (sync_abort) nabort++;
        end
    end

    // stimulus state
    logic [7:0] pkt [0:15];
    int         npkt = 0;
    int         adj = 0;
    int         per_cnt = 0;
    int         ones = 0;
    logic [1:0] cur = 2'b01;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        nwr = 0; ndone = 0; nabort = 0; last_len = -1; last_ign = -1;
    endtask

    task automatic tx_level(input logic [1:0] lv);
        int len;
        {dp, dm} = lv;
        len = OSR;
        if (adj != 0 && per_cnt % 4 == 3) len = OSR + adj;
        per_cnt++;
        repeat (len) @(negedge clk);
    endtask

    task automatic flip_send();
        cur = (cur == 2'b01) ? 2'b10 : 2'b01;
        tx_level(cur);
    endtask

    task automatic tx_bit(input logic b);
        if (!b) flip_send();
        else tx_level(cur);
        if (b) ones++;
        else ones = 0;
        if (ones == 6) begin
            flip_send();
            ones = 0;
        end
    endtask

    task automatic tx_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) tx_bit(v[i]);
    endtask

    // sync, npkt bytes, nextra zero bits, then two periods of end_lv and idle
    task automatic send(input int nextra, input logic [1:0] end_lv);
        per_cnt = 0; ones = 0; cur = 2'b01;
        tx_byte(8'h80);
        for (int i = 0; i < npkt; i++) tx_byte(pkt[i]);
        for (int i = 0; i < nextra; i++) tx_bit(1'b0);
        tx_level(end_lv);
        tx_level(end_lv);
        cur = 2'b01;
        tx_level(2'b01);
        repeat (4 * OSR) @(negedge clk);
    endtask

    task automatic expect_pkt(input string req, input int ign_exp);
        int n;
        n = (npkt > DEPTH) ? DEPTH : npkt;
        chk({req, " bytes written"}, nwr, n);
        for (int i = 0; i < n && i < nwr; i++) begin
            chk({req, " data"}, int'(got_data[i]), int'(pkt[i]));
            chk({req, " index"}, got_idx[i], i);
        end
        chk({req, " done count"}, ndone, 1);
        chk({req, " length"}, last_len, n);
        chk({req, " ignored"}, last_ign, ign_exp);
        chk({req, " no abort"}, nabort, 0);
    endtask

    task automatic t_reset();
        chk("R1 wr_en in reset", int'(wr_en), 0);
        chk("R1 pkt_done in reset", int'(pkt_done), 0);
        chk("R1 sync_abort in reset", int'(sync_abort), 0);
        @(negedge clk); rst = 1'b0;
        clear_mon();
        repeat (10 * OSR) @(negedge clk);
        chk("R1 idle writes", nwr, 0);
        chk("R1 idle done", ndone, 0);
        chk("R1 idle abort", nabort, 0);
    endtask

    task automatic t_basic();
        clear_mon(); adj = 0;
        pkt[0] = 8'hC3; pkt[1] = 8'h5A; pkt[2] = 8'h01; npkt = 3;
        send(0, 2'b00);
        expect_pkt("R2 R4 R7 basic", 0);
    endtask

    task automatic t_stuff();
        clear_mon(); adj = 0;
        pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h7E; npkt = 3;
        send(0, 2'b00);
        expect_pkt("R5 long ones", 0);
    endtask

    task automatic t_stuff_first();
        clear_mon(); adj = 0;
        pkt[0] = 8'h3F; pkt[1] = 8'h81; npkt = 2;
        send(0, 2'b00);
        expect_pkt("R5 stuff after sync", 0);
    endtask

    task automatic t_zero_reset();
        clear_mon(); adj = 0;
        pkt[0] = 8'hDF; pkt[1] = 8'hBE; pkt[2] = 8'hF7; npkt = 3;
        send(0, 2'b00);
        expect_pkt("R6 zero clears run", 0);
    endtask

    task automatic t_partial();
        clear_mon(); adj = 0;
        pkt[0] = 8'hA5; npkt = 1;
        send(3, 2'b00);
        expect_pkt("R7 partial byte", 0);
    endtask

    task automatic t_empty();
        clear_mon(); adj = 0; npkt = 0;
        send(0, 2'b00);
        chk("R7 empty writes", nwr, 0);
        chk("R7 empty done", ndone, 1);
        chk("R7 empty length", last_len, 0);
    endtask

    task automatic t_full();
        clear_mon(); adj = 0;
        pkt[0] = 8'h11; pkt[1] = 8'h22; pkt[2] = 8'h33; pkt[3] = 8'h44; npkt = 4;
        send(0, 2'b00);
        expect_pkt("R8 exactly full", 0);
    endtask

    task automatic t_ovf();
        clear_mon(); adj = 0;
        for (int i = 0; i < 6; i++) pkt[i] = 8'(8'h90 + i);
        npkt = 6;
        send(0, 2'b00);
        expect_pkt("R8 overflow", 1);
    endtask

    task automatic t_bad();
        clear_mon(); adj = 0;
        pkt[0] = 8'h4C; pkt[1] = 8'hE2; npkt = 2;
        send(0, 2'b11);
        expect_pkt("R9 both high", 1);
    endtask

    task automatic t_abort_jj();
        clear_mon(); adj = 0; per_cnt = 0;
        tx_level(2'b10); tx_level(2'b01); tx_level(2'b10);
        tx_level(2'b01); tx_level(2'b01);
        repeat (4 * OSR) @(negedge clk);
        chk("R3 double J abort", nabort, 1);
        chk("R3 double J no done", ndone, 0);
        chk("R3 double J no write", nwr, 0);
    endtask

    task automatic t_abort_se0();
        clear_mon(); adj = 0; per_cnt = 0;
        tx_level(2'b10); tx_level(2'b01); tx_level(2'b00);
        tx_level(2'b01);
        repeat (4 * OSR) @(negedge clk);
        chk("R3 SE0 abort", nabort, 1);
        chk("R3 SE0 no done", ndone, 0);
        clear_mon();
        pkt[0] = 8'h6D; npkt = 1;
        send(0, 2'b00);
        expect_pkt("R3 rehunt after abort", 0);
    endtask

    task automatic t_drift(input int a);
        clear_mon(); adj = a;
        pkt[0] = 8'hFF; pkt[1] = 8'h00; pkt[2] = 8'h3C; pkt[3] = 8'hF0; npkt = 4;
        send(0, 2'b00);
        expect_pkt(a > 0 ? "R10 stretched bits" : "R10 shrunk bits", 0);
        adj = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        t_basic();
        t_stuff();
        t_stuff_first();
        t_zero_reset();
        t_partial();
        t_empty();
        t_full();
        t_ovf();
        t_bad();
        t_abort_jj();
        t_abort_se0();
        t_drift(1);
        t_drift(-1);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule